// File: doc/BRIEF.md
# Memory Frequency Change Sequencer

This block carries out a hardware-run change of the memory clock frequency. Software writes new refresh timing into a staging copy, then sets a start bit in the control word. The sequencer waits until every bus master either reports ready or has been masked off. It then places the memory in self-refresh and, when the control word asks for it, holds the memory pads. Next it requests the clock switch and waits for the clock source to report done. It applies the staged refresh timing in one cycle, brings the memory back out of self-refresh and clears the start bit. Software polls that bit to learn that the change has completed.

The register port is a plain single-cycle write strobe with a combinational read of the addressed word. Word 0 is control, word 1 is the master mask, word 2 is the live refresh timing and word 3 is the staging copy (read-only). The control bit positions are fixed because software composes them: bit 0 start, bit 1 mode, bit 4 bypass, bit 13 pad hold, bit 15 double buffering. The timing word carries the refresh interval in units of 32 clocks in bits 31:16 and the refresh cycle time in clocks in bits 15:0. The block only passes that word to the memory controller and does not interpret it. The self-refresh and clock-switch handshakes are level based: a request stays high until its answer arrives.

Top module: `mfreq_seq`

## Requirements
- R1: After reset the control word and the mask read 0, the live and staging timing words both equal TIMING_RST, and sr_req, clk_sw_req and pad_hold are 0.
- R2: A control write with bit 0 = 1 and bit 1 = 0 made while idle sets the start bit, which reads 1 until the cycle after sr_ack is seen low in the exit step, and then reads 0. A control write with bit 1 = 1 (continuous mode) stores the mode bit but never sets start or begins a sequence.
- R3: sr_req rises exactly one cycle after a cycle in which the sequence is waiting and every master i has mst_ready[i] = 1 or mask bit i = 1. Until then it stays 0.
- R4: sr_req stays high from its rise through the commit cycle and drops in the cycle after the commit. pad_hold is 1 from the cycle after sr_ack is first seen high until the cycle after sr_ack is seen low again, but only when control bit 13 is 1. Otherwise it stays 0.
- R5: clk_sw_req rises in the cycle after sr_ack is seen high and stays high until clk_sw_done is seen high. With control bit 4 (bypass) set, the clock switch step is skipped and clk_sw_req stays 0.
- R6: With control bit 15 = 1, writes to word 2 update only the staging copy (readable at word 3). timing_act keeps its value until the commit cycle and takes the staged value from the cycle in which sr_req drops.
- R7: With control bit 15 = 0, a write to word 2 changes timing_act in the next cycle, and a sequence leaves timing_act unchanged even when the staging copy differs.
- R8: Writes to the control word while start reads 1 are ignored completely. Mask and timing writes are still accepted.
- R9: The mask has NUM_MASTERS bits. Bits at or above NUM_MASTERS read as 0 and are discarded on write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word select for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word |
| mst_ready | input | NUM_MASTERS | Per-master ready for a frequency change |
| sr_req | output | 1 | Self-refresh request (level) |
| sr_ack | input | 1 | Memory reports it is in self-refresh |
| pad_hold | output | 1 | Hold the memory pads |
| clk_sw_req | output | 1 | Request the memory clock switch |
| clk_sw_done | input | 1 | Clock switch finished |
| timing_act | output | 32 | Live refresh timing word |

## Verification
The bench builds the block with NUM_MASTERS = 4. At that size every pairing of a 4-bit mask with a 4-bit ready pattern, 256 in all, can drive a complete sequence, and the bench checks the gate decision against the arithmetic OR of mask and ready for each pairing. The small width also lets the bench verify mask truncation by writing all ones. Directed sequences then cover staged and direct timing writes, bypass, pad hold on and off, a refused continuous-mode start and a control write made in mid-sequence.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
  localparam int unsigned REG_W = 32;

  localparam logic [1:0] A_CTRL   = 2'd0;
  localparam logic [1:0] A_MASK   = 2'd1;
  localparam logic [1:0] A_TIME   = 2'd2;
  localparam logic [1:0] A_STAGE  = 2'd3;

  localparam int unsigned CB_START = 0;
  localparam int unsigned CB_MODE  = 1;
  localparam int unsigned CB_BYP   = 4;
  localparam int unsigned CB_HOLD  = 13;
  localparam int unsigned CB_DBUF  = 15;

  typedef struct packed {
    logic dbuf;
    logic hold;
    logic byp;
    logic mode;
    logic start;
  } ctrl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GATE,
    ST_SR_IN,
    ST_CLK,
    ST_COMMIT,
    ST_SR_OUT
  } seq_state_e;
endpackage

// File: rtl/mfs_regs.sv
module mfs_regs
  import mfs_pkg::*;
#(
  parameter int unsigned NUM_MASTERS = 32,
  parameter logic [REG_W-1:0] TIMING_RST = 32'h00F0_0020
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [1:0]             addr,
  input  logic [REG_W-1:0]       wdata,
  input  logic                   seq_done,
  input  logic                   commit,
  output logic [REG_W-1:0]       rdata,
  output ctrl_t                  ctrl,
  output logic [NUM_MASTERS-1:0] mask,
  output logic [REG_W-1:0]       timing_act
);
  logic [REG_W-1:0] timing_stage;
  logic wr_ctrl, wr_mask, wr_time;

  assign wr_ctrl = we && (addr == A_CTRL) && !ctrl.start;
  assign wr_mask = we && (addr == A_MASK);
  assign wr_time = we && (addr == A_TIME);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_ctrl) begin
      ctrl.start <= wdata[CB_START] & ~wdata[CB_MODE];
      ctrl.mode  <= wdata[CB_MODE];
      ctrl.byp   <= wdata[CB_BYP];
      ctrl.hold  <= wdata[CB_HOLD];
      ctrl.dbuf  <= wdata[CB_DBUF];
    end else if (seq_done) begin
      ctrl.start <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask <= '0;
    else if (wr_mask) mask <= wdata[NUM_MASTERS-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timing_act   <= TIMING_RST;
      timing_stage <= TIMING_RST;
    end else begin
      if (wr_time && ctrl.dbuf) timing_stage <= wdata;
      if (wr_time && !ctrl.dbuf) timing_act <= wdata;
      else if (commit && ctrl.dbuf) timing_act <= timing_stage;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[CB_START] = ctrl.start;
        rdata[CB_MODE]  = ctrl.mode;
        rdata[CB_BYP]   = ctrl.byp;
        rdata[CB_HOLD]  = ctrl.hold;
        rdata[CB_DBUF]  = ctrl.dbuf;
      end
      A_MASK:  rdata = REG_W'(mask);
      A_TIME:  rdata = timing_act;
      default: rdata = timing_stage;
    endcase
  end
endmodule

// File: rtl/mfs_gate.sv
module mfs_gate #(
  parameter int unsigned NUM_MASTERS = 32
) (
  input  logic [NUM_MASTERS-1:0] ready,
  input  logic [NUM_MASTERS-1:0] mask,
  output logic                   all_ok
);
  logic [NUM_MASTERS-1:0] ok;

  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_mst
    assign ok[i] = ready[i] | mask[i];
  end

  assign all_ok = &ok;
endmodule

// File: rtl/mfs_fsm.sv
module mfs_fsm
  import mfs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic bypass,
  input  logic hold_en,
  input  logic all_ok,
  input  logic sr_ack,
  input  logic clk_sw_done,
  output logic sr_req,
  output logic clk_sw_req,
  output logic pad_hold,
  output logic commit,
  output logic seq_done
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:   if (start) st_d = ST_GATE;
      ST_GATE:   if (all_ok) st_d = ST_SR_IN;
      ST_SR_IN:  if (sr_ack) st_d = bypass ? ST_COMMIT : ST_CLK;
      ST_CLK:    if (clk_sw_done) st_d = ST_COMMIT;
      ST_COMMIT: st_d = ST_SR_OUT;
      ST_SR_OUT: if (!sr_ack) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else st_q <= st_d;
  end

  assign sr_req     = (st_q == ST_SR_IN) || (st_q == ST_CLK) || (st_q == ST_COMMIT);
  assign clk_sw_req = (st_q == ST_CLK);
  assign pad_hold   = hold_en &&
                      ((st_q == ST_CLK) || (st_q == ST_COMMIT) || (st_q == ST_SR_OUT));
  assign commit     = (st_q == ST_COMMIT);
  assign seq_done   = (st_q == ST_SR_OUT) && !sr_ack;
endmodule

// File: rtl/mfreq_seq.sv
module mfreq_seq
  import mfs_pkg::*;
#(
  parameter int unsigned NUM_MASTERS = 32,
  parameter logic [31:0] TIMING_RST  = 32'h00F0_0020
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_we,
  input  logic [1:0]             reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic [NUM_MASTERS-1:0] mst_ready,
  output logic                   sr_req,
  input  logic                   sr_ack,
  output logic                   pad_hold,
  output logic                   clk_sw_req,
  input  logic                   clk_sw_done,
  output logic [31:0]            timing_act
);
  ctrl_t                  ctrl_q;
  logic [NUM_MASTERS-1:0] mask_q;
  logic                   all_ok, commit, seq_done;

  mfs_regs #(.NUM_MASTERS(NUM_MASTERS), .TIMING_RST(TIMING_RST)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .seq_done   (seq_done),
    .commit     (commit),
    .rdata      (reg_rdata),
    .ctrl       (ctrl_q),
    .mask       (mask_q),
    .timing_act (timing_act)
  );

  mfs_gate #(.NUM_MASTERS(NUM_MASTERS)) u_gate (
    .ready  (mst_ready),
    .mask   (mask_q),
    .all_ok (all_ok)
  );

  mfs_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (ctrl_q.start),
    .bypass      (ctrl_q.byp),
    .hold_en     (ctrl_q.hold),
    .all_ok      (all_ok),
    .sr_ack      (sr_ack),
    .clk_sw_done (clk_sw_done),
    .sr_req      (sr_req),
    .clk_sw_req  (clk_sw_req),
    .pad_hold    (pad_hold),
    .commit      (commit),
    .seq_done    (seq_done)
  );
endmodule

// File: rtl/mfs_seq_chk.sv
module mfs_seq_chk #(
  parameter int unsigned NUM_MASTERS = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_MASTERS-1:0] mst_ready,
  input logic [NUM_MASTERS-1:0] mask,
  input logic                   sr_req,
  input logic                   sr_ack,
  input logic                   pad_hold,
  input logic                   clk_sw_req,
  input logic                   bypass,
  input logic [31:0]            timing_act,
  input logic                   commit,
  input logic                   reg_we,
  input logic [1:0]             reg_addr,
  input logic                   start
);
  // R3
  gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_req) |-> $past(&(mst_ready | mask)));

  // R5
  clk_in_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sw_req |-> sr_req);

  // R5
  bypass_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sw_req |-> !bypass);

  // R4
  hold_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pad_hold) |-> $past(sr_ack));

  // R6
  act_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(timing_act) |-> $past(commit || (reg_we && reg_addr == 2'd2)));

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start) |-> $past(!sr_req && !sr_ack));
endmodule

bind mfreq_seq mfs_seq_chk #(.NUM_MASTERS(NUM_MASTERS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mst_ready  (mst_ready),
  .mask       (mask_q),
  .sr_req     (sr_req),
  .sr_ack     (sr_ack),
  .pad_hold   (pad_hold),
  .clk_sw_req (clk_sw_req),
  .bypass     (ctrl_q.byp),
  .timing_act (timing_act),
  .commit     (commit),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .start      (ctrl_q.start)
);

// File: tb/mfreq_seq_test.sv
module mfreq_seq_test;
  localparam int unsigned NM = 4;
  localparam logic [31:0] TRST = 32'h00F0_0020;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NM-1:0] mst_ready = '0;
  logic sr_req, sr_ack = 1'b0, pad_hold, clk_sw_req, clk_sw_done = 1'b0;
  logic [31:0] timing_act;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  mfreq_seq #(.NUM_MASTERS(NM), .TIMING_RST(TRST)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mst_ready(mst_ready),
    .sr_req(sr_req), .sr_ack(sr_ack), .pad_hold(pad_hold),
    .clk_sw_req(clk_sw_req), .clk_sw_done(clk_sw_done), .timing_act(timing_act)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // Entered with sr_req high and sr_ack low (self-refresh entry pending).
  task automatic full_seq(input logic byp, input logic hold, input logic [31:0] exp_act,
                          input logic [31:0] old_act);
    logic [31:0] v;
    check("R4 no hold before ack", {31'd0, pad_hold}, 32'd0);
    check("R5 no switch before ack", {31'd0, clk_sw_req}, 32'd0);
    sr_ack = 1'b1;
    @(negedge clk);
    if (!byp) begin
      check("R5 switch req", {31'd0, clk_sw_req}, 32'd1);
      check("R4 pad hold", {31'd0, pad_hold}, {31'd0, hold});
      check("R6 act before commit", timing_act, old_act);
      @(negedge clk);
      check("R5 switch req held", {31'd0, clk_sw_req}, 32'd1);
      clk_sw_done = 1'b1;
      @(negedge clk);
      clk_sw_done = 1'b0;
    end else begin
      check("R5 bypass no switch", {31'd0, clk_sw_req}, 32'd0);
    end
    check("R4 sr_req in commit", {31'd0, sr_req}, 32'd1);
    @(negedge clk);
    check("R4 sr_req dropped", {31'd0, sr_req}, 32'd0);
    check("R4 pad hold in exit", {31'd0, pad_hold}, {31'd0, hold});
    check("R6/R7 act after commit", timing_act, exp_act);
    rd(2'd0, v);
    check("R2 start busy", {31'd0, v[0]}, 32'd1);
    sr_ack = 1'b0;
    @(negedge clk);
    check("R4 hold released", {31'd0, pad_hold}, 32'd0);
    rd(2'd0, v);
    check("R2 start cleared", {31'd0, v[0]}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 32'd0);
    rd(2'd1, v); check("R1 mask", v, 32'd0);
    rd(2'd2, v); check("R1 act", v, TRST);
    rd(2'd3, v); check("R1 stage", v, TRST);
    check("R1 outs", {29'd0, sr_req, clk_sw_req, pad_hold}, 32'd0);

    // R9 mask width
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v); check("R9 mask trunc", v, 32'h0000_000F);
    wr(2'd1, 32'h0000_0005); rd(2'd1, v); check("R9 mask value", v, 32'h0000_0005);

    // R7 direct timing write
    wr(2'd2, 32'h1111_2222);
    check("R7 direct write", timing_act, 32'h1111_2222);

    // R6 staged write
    wr(2'd0, 32'h0000_8000);
    wr(2'd2, 32'h3333_4444);
    check("R6 act unchanged", timing_act, 32'h1111_2222);
    rd(2'd3, v); check("R6 stage", v, 32'h3333_4444);

    // R2 continuous mode start refused
    wr(2'd0, 32'h0000_8003);
    rd(2'd0, v); check("R2 mode start refused", v, 32'h0000_8002);
    repeat (3) @(negedge clk);
    check("R2 no sequence", {31'd0, sr_req}, 32'd0);

    // Full staged sequence with pad hold; R8 control write mid-sequence
    wr(2'd1, 32'h0000_000F);
    wr(2'd0, 32'h0000_A001);
    @(negedge clk); @(negedge clk);
    check("R3 gate open", {31'd0, sr_req}, 32'd1);
    wr(2'd0, 32'h0000_0010);
    rd(2'd0, v); check("R8 ctrl write ignored", v, 32'h0000_A001);
    wr(2'd1, 32'h0000_000F);
    rd(2'd1, v); check("R8 mask write accepted", v, 32'h0000_000F);
    full_seq(1'b0, 1'b1, 32'h3333_4444, 32'h1111_2222);

    // R7 no commit with double buffering off; R5 bypass
    wr(2'd0, 32'h0000_0000);
    wr(2'd2, 32'h5555_6666);
    rd(2'd3, v); check("R7 stage untouched", v, 32'h3333_4444);
    wr(2'd0, 32'h0000_0011);
    @(negedge clk); @(negedge clk);
    check("R3 gate open bypass", {31'd0, sr_req}, 32'd1);
    full_seq(1'b1, 1'b0, 32'h5555_6666, 32'h5555_6666);

    // R3 exhaustive mask x ready sweep
    for (int m = 0; m < 16; m++) begin
      for (int r = 0; r < 16; r++) begin
        logic open;
        open = ((m | r) == 15);
        wr(2'd1, 32'(m));
        mst_ready = 4'(r);
        wr(2'd0, 32'h0000_0001);
        @(negedge clk); @(negedge clk);
        check($sformatf("R3 gate m=%0d r=%0d", m, r), {31'd0, sr_req}, {31'd0, open});
        if (!open) begin
          @(negedge clk);
          check("R3 stall held", {31'd0, sr_req}, 32'd0);
          mst_ready = 4'hF;
          @(negedge clk);
          check("R3 gate after ready", {31'd0, sr_req}, 32'd1);
        end
        full_seq(1'b0, 1'b0, 32'h5555_6666, 32'h5555_6666);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule